// File: doc/BRIEF.md
# Floating-Point Control Register with Accuracy-Mode Trap Logic

This block holds the floating-point control and status word that a core keeps next to its floating-point unit. The word has three fields. The first holds sticky exception flags. The second holds the dynamic rounding mode. The third is an accuracy field, which selects the minimum result accuracy that software asks for. Software reads and writes the word through a plain write-enable and data port. The floating-point unit sets flags in it when an operation completes.

For every issued floating-point instruction, the block works out the rounding mode and the accuracy mode that the datapath must use. The instruction supplies its static rounding field and an operation class, and the block resolves both modes from these and the stored word. It raises an illegal-instruction trap request in two cases: the dynamic rounding value is invalid, or the requested accuracy is not available for that class. The trap lets a handler emulate the operation. A parameter table states which accuracy modes each operation class supports. A second parameter lets the hardware serve an unsupported request with a more accurate supported mode instead of trapping. Operand and result formats never depend on the accuracy mode.

Top module: `fpc_ctrl`

## Requirements
- R1: After reset `csr_rdata` is zero, so the flags, the rounding field and the accuracy field are all 000/00000.
- R2: A write with `csr_we` stores `csr_wdata[10:0]` into the word. The flags go in bits 4..0, the dynamic rounding mode in bits 7..5 and the accuracy field in bits 10..8. Bits 31..11 of `csr_rdata` always read zero, whatever was written.
- R3: When `flag_set_valid` is high and `csr_we` is low, `flag_set` is OR-ed into bits 4..0 at the next clock. Flags already set stay set.
- R4: When `csr_we` and `flag_set_valid` are high in the same cycle, the written value wins completely and `flag_set` is lost.
- R5: `eff_rm` equals `issue_rm` when `issue_rm` is not 111. When `issue_rm` is 111, `eff_rm` equals the stored dynamic rounding field.
- R6: When `issue_valid` is high, `issue_rm` is 111 and the stored rounding field is 101, 110 or 111, then `trap_cause[0]` and `trap_req` are 1. Otherwise `trap_cause[0]` is 0.
- R7: The accuracy encodings are 000 for correctly rounded, 010 for below one ULP, 100 for graphics-API bound and 110 for approximate. Mode index k is the value of bits 2..1 of the encoding. An odd encoding (001, 011, 101, 111) raises `trap_cause[1]` for every class when `issue_valid` is high.
- R8: Class c supports mode index k when bit `c*4+k` of `SUPPORT_MASK` is 1. With `PROMOTE=0`, a request for an even encoding whose mode is not supported by `issue_class` raises `trap_cause[1]`. A supported request gives `eff_acc` equal to the stored field.
- R9: Accuracy 000 never raises `trap_cause[1]`, for any class. This holds even when the mask bit for that class is 0.
- R10: With `PROMOTE=1`, an even encoding never traps. `eff_acc` is the encoding of the largest supported mode index that is not above the requested index.
- R11: `trap_cause` is zero when `issue_valid` is low. `trap_req` is the OR of the two cause bits. `eff_acc` is 000 whenever the accuracy check faults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| csr_we | input | 1 | Write strobe for the control word |
| csr_wdata | input | 32 | Write data |
| csr_rdata | output | 32 | Current control word, reserved bits zero |
| flag_set_valid | input | 1 | Flag update from the floating-point unit |
| flag_set | input | 5 | Flags to OR into the sticky field |
| issue_valid | input | 1 | A floating-point instruction is being issued |
| issue_rm | input | 3 | Static rounding field of the instruction |
| issue_class | input | CLS_W | Operation class of the instruction |
| eff_rm | output | 3 | Rounding mode the datapath must use |
| eff_acc | output | 3 | Accuracy mode the datapath must use |
| trap_req | output | 1 | Illegal-instruction trap request |
| trap_cause | output | 2 | Bit 0 rounding fault, bit 1 accuracy fault |

## Verification
The bench builds two copies of the block. Both have four operation classes and the mask 16'h053F, which gives class 0 every mode, class 1 modes 0 and 1, class 2 modes 0 and 2, and class 3 no modes at all. The two copies differ only in `PROMOTE`: one has 0 and the other has 1. The class 3 mask checks that mode 0 is forced on. With this setup, every combination of accuracy field, dynamic rounding field, static rounding field and class can be swept. Each combination is checked against both the trapping and the promoting outcome, and a sparse class exercises the nearest-supported-mode search.

// File: rtl/fpc_pkg.sv
package fpc_pkg;

    localparam int FLAG_W  = 5;
    localparam int RM_W    = 3;
    localparam int ACC_W   = 3;
    localparam int WORD_W  = 32;
    localparam int USED_W  = FLAG_W + RM_W + ACC_W;
    localparam int MODES   = 4;
    localparam int MIDX_W  = 2;

    localparam logic [RM_W-1:0]  RM_DYNAMIC   = 3'b111;
    localparam logic [RM_W-1:0]  RM_FIRST_BAD = 3'b101;
    localparam logic [ACC_W-1:0] ACC_EXACT    = 3'b000;

    typedef struct packed {
        logic [ACC_W-1:0]  acc;
        logic [RM_W-1:0]   frm;
        logic [FLAG_W-1:0] fflags;
    } ctrl_word_t;

    typedef struct packed {
        logic rm_fault;
        logic acc_fault;
    } fault_t;

endpackage

// File: rtl/fpc_word_reg.sv
module fpc_word_reg
    import fpc_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [USED_W-1:0]   wr_data,
    input  logic                flag_valid,
    input  logic [FLAG_W-1:0]   flag_bits,
    output ctrl_word_t          word_q
);

    ctrl_word_t word_d;

    always_comb begin
        word_d = word_q;
        if (flag_valid) begin
            word_d.fflags = word_q.fflags | flag_bits;
        end
        if (wr_en) begin
            word_d = ctrl_word_t'(wr_data);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= '0;
        end else begin
            word_q <= word_d;
        end
    end

endmodule

// File: rtl/fpc_rm_resolve.sv
module fpc_rm_resolve
    import fpc_pkg::*;
(
    input  logic [RM_W-1:0] static_rm,
    input  logic [RM_W-1:0] dyn_rm,
    output logic [RM_W-1:0] rm_out,
    output logic            rm_bad
);

    logic use_dyn;

    always_comb begin
        use_dyn = (static_rm == RM_DYNAMIC);
        rm_out  = use_dyn ? dyn_rm : static_rm;
        rm_bad  = use_dyn && (dyn_rm >= RM_FIRST_BAD);
    end

endmodule

// File: rtl/fpc_acc_check.sv
module fpc_acc_check
    import fpc_pkg::*;
#(
    parameter int                         NUM_CLASSES  = 4,
    parameter int                         CLS_W        = 2,
    parameter logic [MODES*NUM_CLASSES-1:0] SUPPORT_MASK = '1,
    parameter bit                         PROMOTE      = 1'b0
) (
    input  logic [ACC_W-1:0] acc_req,
    input  logic [CLS_W-1:0] cls,
    output logic [ACC_W-1:0] acc_out,
    output logic             acc_bad
);

    localparam int ROWS = 2 ** CLS_W;
    localparam logic [MODES-1:0] EXACT_BIT = {{(MODES-1){1'b0}}, 1'b1};

    logic [MODES-1:0]  row_mask [ROWS];
    logic [MODES-1:0]  row;
    logic [MIDX_W-1:0] req_idx;
    logic [MIDX_W-1:0] served_idx;
    logic              odd_code;
    logic              no_serve;

    for (genvar g = 0; g < ROWS; g++) begin : g_rows
        if (g < NUM_CLASSES) begin : g_real
            assign row_mask[g] = SUPPORT_MASK[g*MODES +: MODES] | EXACT_BIT;
        end else begin : g_pad
            assign row_mask[g] = EXACT_BIT;
        end
    end

    assign row      = row_mask[cls];
    assign req_idx  = acc_req[ACC_W-1:1];
    assign odd_code = acc_req[0];

    if (PROMOTE) begin : g_promote
        always_comb begin
            served_idx = '0;
            for (int j = 0; j < MODES; j++) begin
                if (row[j] && (j <= int'(req_idx))) begin
                    served_idx = MIDX_W'(j);
                end
            end
            no_serve = 1'b0;
        end
    end else begin : g_strict
        always_comb begin
            served_idx = req_idx;
            no_serve   = !row[req_idx];
        end
    end

    always_comb begin
        acc_bad = odd_code || no_serve;
        acc_out = acc_bad ? ACC_EXACT : {served_idx, 1'b0};
    end

endmodule

// File: rtl/fpc_ctrl.sv
module fpc_ctrl
    import fpc_pkg::*;
#(
    parameter int NUM_CLASSES = 4,
    parameter logic [MODES*NUM_CLASSES-1:0] SUPPORT_MASK = '1,
    parameter bit PROMOTE = 1'b0,
    localparam int CLS_W = (NUM_CLASSES > 1) ? $clog2(NUM_CLASSES) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               csr_we,
    input  logic [WORD_W-1:0]  csr_wdata,
    output logic [WORD_W-1:0]  csr_rdata,
    input  logic               flag_set_valid,
    input  logic [FLAG_W-1:0]  flag_set,
    input  logic               issue_valid,
    input  logic [RM_W-1:0]    issue_rm,
    input  logic [CLS_W-1:0]   issue_class,
    output logic [RM_W-1:0]    eff_rm,
    output logic [ACC_W-1:0]   eff_acc,
    output logic               trap_req,
    output logic [1:0]         trap_cause
);

    ctrl_word_t word_q;
    logic       rm_bad;
    logic       acc_bad;
    fault_t     fault;

    fpc_word_reg u_reg (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (csr_we),
        .wr_data    (csr_wdata[USED_W-1:0]),
        .flag_valid (flag_set_valid),
        .flag_bits  (flag_set),
        .word_q     (word_q)
    );

    fpc_rm_resolve u_rm (
        .static_rm (issue_rm),
        .dyn_rm    (word_q.frm),
        .rm_out    (eff_rm),
        .rm_bad    (rm_bad)
    );

    fpc_acc_check #(
        .NUM_CLASSES  (NUM_CLASSES),
        .CLS_W        (CLS_W),
        .SUPPORT_MASK (SUPPORT_MASK),
        .PROMOTE      (PROMOTE)
    ) u_acc (
        .acc_req (word_q.acc),
        .cls     (issue_class),
        .acc_out (eff_acc),
        .acc_bad (acc_bad)
    );

    always_comb begin
        fault.rm_fault  = issue_valid && rm_bad;
        fault.acc_fault = issue_valid && acc_bad;
        trap_cause      = {fault.acc_fault, fault.rm_fault};
        trap_req        = fault.rm_fault || fault.acc_fault;
        csr_rdata       = {{(WORD_W-USED_W){1'b0}}, word_q};
    end

endmodule

// File: rtl/fpc_ctrl_chk.sv
module fpc_ctrl_chk #(
    parameter int CLS_W = 2
) (
    input logic        clk,
    input logic        rst_n,
    input logic        csr_we,
    input logic [31:0] csr_wdata,
    input logic [31:0] csr_rdata,
    input logic        flag_set_valid,
    input logic        issue_valid,
    input logic [2:0]  issue_rm,
    input logic [CLS_W-1:0] issue_class,
    input logic [2:0]  eff_rm,
    input logic [2:0]  eff_acc,
    input logic        trap_req,
    input logic [1:0]  trap_cause
);

    p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        csr_rdata[31:11] == 21'd0);

    p_write_stored_r2: assert property (@(posedge clk) disable iff (!rst_n)
        csr_we |=> csr_rdata[10:0] == $past(csr_wdata[10:0]));

    p_flags_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !csr_we |=> (csr_rdata[4:0] & $past(csr_rdata[4:0])) == $past(csr_rdata[4:0]));

    p_static_rm_r5: assert property (@(posedge clk) disable iff (!rst_n)
        issue_rm != 3'b111 |-> eff_rm == issue_rm);

    p_bad_dyn_rm_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && issue_rm == 3'b111 && csr_rdata[7:5] >= 3'b101) |-> (trap_cause[0] && trap_req));

    p_odd_acc_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && csr_rdata[8]) |-> trap_cause[1]);

    p_exact_ok_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_rdata[10:8] == 3'b000) |-> !trap_cause[1]);

    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !issue_valid |-> (trap_cause == 2'b00 && !trap_req));

    p_fault_exact_r11: assert property (@(posedge clk) disable iff (!rst_n)
        trap_cause[1] |-> eff_acc == 3'b000);

endmodule

bind fpc_ctrl fpc_ctrl_chk #(.CLS_W(CLS_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .csr_we         (csr_we),
    .csr_wdata      (csr_wdata),
    .csr_rdata      (csr_rdata),
    .flag_set_valid (flag_set_valid),
    .issue_valid    (issue_valid),
    .issue_rm       (issue_rm),
    .issue_class    (issue_class),
    .eff_rm         (eff_rm),
    .eff_acc        (eff_acc),
    .trap_req       (trap_req),
    .trap_cause     (trap_cause)
);

// File: tb/fpc_ctrl_tb.sv
module fpc_ctrl_tb;

    localparam logic [15:0] MASK = 16'h053F;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        csr_we = 1'b0;
    logic [31:0] csr_wdata = '0;
    logic        flag_set_valid = 1'b0;
    logic [4:0]  flag_set = '0;
    logic        issue_valid = 1'b0;
    logic [2:0]  issue_rm = '0;
    logic [1:0]  issue_class = '0;

    logic [31:0] rd_s, rd_p;
    logic [2:0]  rm_s, rm_p, acc_s, acc_p;
    logic        tr_s, tr_p;
    logic [1:0]  tc_s, tc_p;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    fpc_ctrl #(.NUM_CLASSES(4), .SUPPORT_MASK(MASK), .PROMOTE(1'b0)) u_dut (
        .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_wdata(csr_wdata),
        .csr_rdata(rd_s), .flag_set_valid(flag_set_valid), .flag_set(flag_set),
        .issue_valid(issue_valid), .issue_rm(issue_rm), .issue_class(issue_class),
        .eff_rm(rm_s), .eff_acc(acc_s), .trap_req(tr_s), .trap_cause(tc_s));

    fpc_ctrl #(.NUM_CLASSES(4), .SUPPORT_MASK(MASK), .PROMOTE(1'b1)) u_dut_p (
        .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_wdata(csr_wdata),
        .csr_rdata(rd_p), .flag_set_valid(flag_set_valid), .flag_set(flag_set),
        .issue_valid(issue_valid), .issue_rm(issue_rm), .issue_class(issue_class),
        .eff_rm(rm_p), .eff_acc(acc_p), .trap_req(tr_p), .trap_cause(tc_p));

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic bit supp(input int c, input int k);
        return (k == 0) || MASK[c*4+k];
    endfunction

    task automatic write_word(input logic [31:0] v);
        @(negedge clk);
        csr_we = 1'b1;
        csr_wdata = v;
        @(negedge clk);
        csr_we = 1'b0;
    endtask

    initial begin
        #1000000;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset word strict", rd_s, 32'd0);
        check("R1 reset word promote", rd_p, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        flag_set_valid = 1'b1;
        flag_set = 5'b00101;
        @(negedge clk);
        flag_set = 5'b10000;
        @(negedge clk);
        flag_set_valid = 1'b0;
        check("R3 flags accumulate", rd_s, 32'h15);
        check("R3 flags accumulate promote", rd_p, 32'h15);

        @(negedge clk);
        csr_we = 1'b1;
        csr_wdata = 32'h0000_0002;
        flag_set_valid = 1'b1;
        flag_set = 5'b11001;
        @(negedge clk);
        csr_we = 1'b0;
        flag_set_valid = 1'b0;
        check("R4 write beats flag OR", rd_s, 32'h2);

        // R11: invalid dynamic rounding and odd accuracy, but nothing issued
        write_word(32'h0000_01E0);
        issue_valid = 1'b0;
        issue_rm = 3'b111;
        #1;
        check("R11 idle cause zero", {31'd0, tr_s}, 32'd0);
        check("R11 idle cause zero bits", {30'd0, tc_s}, 32'd0);

        for (int a = 0; a < 8; a++) begin
            for (int f = 0; f < 8; f++) begin
                logic [31:0] w;
                w = {21'h1ABCDE, 3'(a), 3'(f), 5'(a ^ f)};
                write_word(w);
                #1;
                check("R2 stored word strict", rd_s, {21'd0, w[10:0]});
                check("R2 stored word promote", rd_p, {21'd0, w[10:0]});
                for (int rm = 0; rm < 8; rm++) begin
                    for (int c = 0; c < 4; c++) begin
                        logic [2:0] e_rm, e_acc_s, e_acc_p;
                        logic       e_rmf, e_accf_s, e_accf_p;
                        int         k, best;
                        issue_valid = 1'b1;
                        issue_rm = 3'(rm);
                        issue_class = 2'(c);
                        #1;
                        e_rm = (rm == 7) ? 3'(f) : 3'(rm);
                        e_rmf = (rm == 7) && (f >= 5);
                        k = a / 2;
                        e_accf_s = (a % 2 == 1) || !supp(c, k);
                        e_acc_s = e_accf_s ? 3'd0 : 3'(a);
                        best = 0;
                        for (int j = 0; j <= k; j++) if (supp(c, j)) best = j;
                        e_accf_p = (a % 2 == 1);
                        e_acc_p = e_accf_p ? 3'd0 : 3'(best * 2);
                        check("R5 eff rm", {29'd0, rm_s}, {29'd0, e_rm});
                        check("R6 rm cause", {31'd0, tc_s[0]}, {31'd0, e_rmf});
                        if (a % 2 == 1)
                            check("R7 odd acc trap", {31'd0, tc_s[1]}, 32'd1);
                        else if (a == 0)
                            check("R9 exact no trap", {31'd0, tc_s[1]}, 32'd0);
                        else
                            check("R8 strict acc cause", {31'd0, tc_s[1]}, {31'd0, e_accf_s});
                        check("R8 strict eff acc", {29'd0, acc_s}, {29'd0, e_acc_s});
                        check("R10 promote cause", {31'd0, tc_p[1]}, {31'd0, e_accf_p});
                        check("R10 promote eff acc", {29'd0, acc_p}, {29'd0, e_acc_p});
                        check("R11 trap_req or", {31'd0, tr_s}, {31'd0, e_rmf | e_accf_s});
                        check("R11 trap_req or promote", {31'd0, tr_p}, {31'd0, e_rmf | e_accf_p});
                    end
                end
                issue_valid = 1'b0;
            end
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule